// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This controller sits between a single-cycle request port inside a clocked design and an external static RAM that has no clock of its own: 65,536 words of 16 bits, with separate byte strobes for the upper and lower halves of each word. A client raises `req` for one cycle while `busy` is low. The request carries a read/write flag, a word address, write data and a two-bit active-low byte mask. The controller then plays out the strobe sequence the memory needs. Every phase lasts a whole number of clock cycles, computed at elaboration from nanosecond limits and the clock period. Each count is the time divided by the period, rounded up, and never less than one cycle.

A read holds chip select and output enable low long enough to cover the access time. It samples the data pins on the last cycle of that window and returns the word on `rdata` with a one-cycle `rvalid` strobe. A write first presents address and data for one setup cycle, then pulses write enable, then releases write enable while address, data and byte strobes stay put for one more hold cycle. After every read the controller keeps off the data pins for a turnaround window, so the memory has time to float its outputs. Between requests chip select is high, which puts the memory in standby. The data pins are exposed as separate out, in and drive-enable signals, and a pad cell outside the block combines them.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_be_n` is 2'b11, `mem_dq_oe`, `busy` and `rvalid` are 0.
- R2: In every cycle in which `busy` is low, `mem_ce_n` is 1 and both bits of `mem_be_n` are 1 (standby).
- R3: During a read, `mem_ce_n` and `mem_oe_n` are 0, `mem_we_n` is 1 and `mem_dq_oe` is 0. Bit 1 of the mask drives the strobe for data bits 15:8 and bit 0 drives bits 7:0, with 0 meaning enabled. A read with mask 2'b00 returns the stored word.
- R4: `mem_oe_n` stays low for exactly N_ACC = max(1, ceil(T_AA_NS / CLK_PERIOD_NS)) consecutive cycles per read. The word is sampled at the end of the last of them. `rvalid` then pulses for exactly one cycle, once per read and never for a write.
- R5: A lane whose mask bit is 1 on a read comes back as zero in `rdata`.
- R6: A write spends one setup cycle with `mem_ce_n` low, `mem_we_n` high and `mem_dq_oe` high. `mem_we_n` is then low for exactly N_WP = max(ceil(T_WP_NS/CLK), ceil(T_DW_NS/CLK), 1) cycles.
- R7: In the cycle after `mem_we_n` rises, `mem_ce_n` is still low, `mem_dq_oe` is still high, and `mem_addr`, `mem_dq_out` and `mem_be_n` are unchanged.
- R8: A write changes only the lanes whose mask bit is 0. A write with mask 2'b11 changes nothing.
- R9: `mem_dq_oe` is never high while `mem_oe_n` is low. After a read, the controller waits at least N_HZ = max(1, ceil(T_HZ_NS/CLK)) cycles with `mem_oe_n` high before it drives the bus again.
- R10: `busy` is high for N_ACC + N_HZ cycles after a read is accepted and for N_WP + 2 cycles after a write is accepted. A `req` raised while `busy` is high is ignored.
- R11: `mem_we_n` and `mem_oe_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, taken when `busy` is low |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address |
| wdata | input | 16 | Write data |
| be_n | input | 2 | Lane mask, active low; bit 1 = bits 15:8 |
| busy | output | 1 | Controller occupied |
| rdata | output | 16 | Read word, masked lanes zero |
| rvalid | output | 1 | One-cycle read completion strobe |
| mem_addr | output | 16 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | 2 | Byte strobes, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 16 | Data from the memory pins |

## Verification
The memory model in the bench returns a junk pattern until output enable has been low for N_ACC cycles. A controller that samples one cycle early therefore hands back junk instead of the stored word. Masked lanes on the pins also carry junk, so a design that forgets the lane mask on reads returns nonzero upper or lower bytes. Writes with one lane masked, and with both lanes masked, are read back to expose a design that writes a whole word regardless of the mask. A write right after a read, a write pulse length that is measured, and a hold cycle that is compared catch a design that drops the turnaround, shortens write enable or changes the address as write enable rises. A request raised during a read must leave the memory untouched; a design that accepts it while busy overwrites the word.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = 2;
    localparam int unsigned DATA_W = LANE_W * LANES;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_RD_ACC   = 3'd1,
        PH_RD_GAP   = 3'd2,
        PH_WR_SETUP = 3'd3,
        PH_WR_PULSE = 3'd4,
        PH_WR_HOLD  = 3'd5
    } sram_phase_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be_n;
    } sram_req_t;

    // Nanoseconds to whole cycles, rounded up, at least one.
    function automatic int unsigned ns_to_cyc(int unsigned t_ns, int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Ones in lanes that are enabled (active-low mask bit is 0).
    function automatic logic [DATA_W-1:0] lane_keep(logic [LANES-1:0] mask_n);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < int'(LANES); i++)
            m[i*LANE_W +: LANE_W] = {LANE_W{~mask_n[i]}};
        return m;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CW'(1));
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned N_ACC = 2,
    parameter int unsigned N_WP  = 2,
    parameter int unsigned N_HZ  = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        req_we,
    output sram_phase_e phase,
    output logic        accept,
    output logic        capture
);
    localparam int unsigned N_MAX = max_u(max_u(N_ACC, N_WP), N_HZ);
    localparam int unsigned CW    = $clog2(N_MAX + 1) + 1;

    sram_phase_e   state, nxt;
    logic          t_load, t_last;
    logic [CW-1:0] t_val;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    always_comb begin
        nxt     = state;
        t_load  = 1'b0;
        t_val   = '0;
        accept  = 1'b0;
        capture = 1'b0;
        case (state)
            PH_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    if (req_we) begin
                        nxt = PH_WR_SETUP;
                    end else begin
                        nxt    = PH_RD_ACC;
                        t_load = 1'b1;
                        t_val  = CW'(N_ACC);
                    end
                end
            end
            PH_RD_ACC: begin
                if (t_last) begin
                    capture = 1'b1;
                    nxt     = PH_RD_GAP;
                    t_load  = 1'b1;
                    t_val   = CW'(N_HZ);
                end
            end
            PH_RD_GAP: begin
                if (t_last) nxt = PH_IDLE;
            end
            PH_WR_SETUP: begin
                nxt    = PH_WR_PULSE;
                t_load = 1'b1;
                t_val  = CW'(N_WP);
            end
            PH_WR_PULSE: begin
                if (t_last) nxt = PH_WR_HOLD;
            end
            PH_WR_HOLD: nxt = PH_IDLE;
            default:    nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PH_IDLE;
        else     state <= nxt;
    end

    assign phase = state;
endmodule

// File: rtl/sram_lane_path.sv
`timescale 1ns/1ps
module sram_lane_path
    import sram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  sram_req_t         req_in,
    input  logic              capture,
    input  sram_phase_e       phase,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    sram_req_t req_q;
    logic      sel, wr_ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (accept) req_q <= req_in;
        end
    end

    assign wr_ph = (phase == PH_WR_SETUP) || (phase == PH_WR_PULSE) || (phase == PH_WR_HOLD);
    assign sel   = wr_ph || (phase == PH_RD_ACC);

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                rdata[g*LANE_W +: LANE_W] <= '0;
            else if (capture)
                rdata[g*LANE_W +: LANE_W] <= req_q.be_n[g] ? '0 : dq_in[g*LANE_W +: LANE_W];
        end
        assign mem_be_n[g] = ~sel | req_q.be_n[g];
    end

    assign mem_addr = req_q.addr;
    assign mem_ce_n = ~sel;
    assign mem_oe_n = ~(phase == PH_RD_ACC);
    assign mem_we_n = ~(phase == PH_WR_PULSE);
    assign dq_out   = req_q.wdata;
    assign dq_oe    = wr_ph;
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned T_AA_NS       = 10,
    parameter int unsigned T_WP_NS       = 7,
    parameter int unsigned T_DW_NS       = 5,
    parameter int unsigned T_HZ_NS       = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  be_n,
    output logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned N_ACC = ns_to_cyc(T_AA_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WP  = max_u(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_DW_NS, CLK_PERIOD_NS));
    localparam int unsigned N_HZ  = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);

    sram_phase_e phase;
    logic        accept, capture;
    sram_req_t   req_in;

    assign req_in = '{we: we, addr: addr, wdata: wdata, be_n: be_n};

    sram_seq_fsm #(.N_ACC(N_ACC), .N_WP(N_WP), .N_HZ(N_HZ)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .req_we  (we),
        .phase   (phase),
        .accept  (accept),
        .capture (capture)
    );

    sram_lane_path u_lanes (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_in   (req_in),
        .capture  (capture),
        .phase    (phase),
        .dq_in    (mem_dq_in),
        .rdata    (rdata),
        .rvalid   (rvalid),
        .mem_addr (mem_addr),
        .mem_ce_n (mem_ce_n),
        .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n),
        .mem_be_n (mem_be_n),
        .dq_out   (mem_dq_out),
        .dq_oe    (mem_dq_oe)
    );

    assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned T_AA_NS       = 10,
    parameter int unsigned T_WP_NS       = 7,
    parameter int unsigned T_DW_NS       = 5,
    parameter int unsigned T_HZ_NS       = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              busy,
    input logic [LANES-1:0]  be_n,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    localparam int unsigned N_ACC = ns_to_cyc(T_AA_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WP  = max_u(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_DW_NS, CLK_PERIOD_NS));
    localparam int unsigned N_HZ  = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);

    logic [7:0]       oe_low, we_low, oe_high;
    logic [LANES-1:0] mask_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_low    <= '0;
            we_low    <= '0;
            oe_high   <= 8'hFF;
            mask_seen <= '1;
        end else begin
            oe_low  <= !mem_oe_n ? ((oe_low  != 8'hFF) ? oe_low  + 8'd1 : oe_low)  : 8'd0;
            we_low  <= !mem_we_n ? ((we_low  != 8'hFF) ? we_low  + 8'd1 : we_low)  : 8'd0;
            oe_high <=  mem_oe_n ? ((oe_high != 8'hFF) ? oe_high + 8'd1 : oe_high) : 8'd0;
            if (req && !busy) mask_seen <= be_n;
        end
    end

    assert_standby_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_ce_n && (&mem_be_n)));

    assert_read_strobes_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

    assert_access_len_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (oe_low == 8'(N_ACC)));

    assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    assert_rvalid_after_oe_R4: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $rose(mem_oe_n));

    assert_lane_zero_R5: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> ((rdata & ~lane_keep(mask_seen)) == '0));

    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low == 8'(N_WP)));

    assert_setup_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(!mem_ce_n && mem_we_n && mem_dq_oe));

    assert_hold_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr)
                             && $stable(mem_dq_out) && $stable(mem_be_n)));

    assert_turnaround_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (oe_high > 8'(N_HZ)));

    assert_no_contend_R11: assert property (@(posedge clk) disable iff (rst)
        mem_we_n || mem_oe_n);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_AA_NS       (T_AA_NS),
    .T_WP_NS       (T_WP_NS),
    .T_DW_NS       (T_DW_NS),
    .T_HZ_NS       (T_HZ_NS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .busy       (busy),
    .be_n       (be_n),
    .rvalid     (rvalid),
    .rdata      (rdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_be_n   (mem_be_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;
    localparam int TB_CLK_NS = 5;
    // Expected phase lengths from the requirements: ceil(10/5)=2, max(ceil(7/5),ceil(5/5))=2, ceil(5/5)=1
    localparam int EXP_ACC = 2;
    localparam int EXP_WP  = 2;
    localparam int EXP_HZ  = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, we = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic [1:0]  be_n = 2'b11;
    logic        busy, rvalid;
    logic [15:0] rdata;
    logic [15:0] mem_addr, mem_dq_out, mem_dq_in;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_be_n;

    always #(TB_CLK_NS / 2.0) clk = ~clk;

    sram_async_ctrl #(
        .CLK_PERIOD_NS (TB_CLK_NS),
        .T_AA_NS (10), .T_WP_NS (7), .T_DW_NS (5), .T_HZ_NS (5)
    ) uut (
        .clk (clk), .rst (rst), .req (req), .we (we), .addr (addr),
        .wdata (wdata), .be_n (be_n), .busy (busy), .rdata (rdata),
        .rvalid (rvalid), .mem_addr (mem_addr), .mem_ce_n (mem_ce_n),
        .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n), .mem_be_n (mem_be_n),
        .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
    );

    // ---------------- memory model ----------------
    logic [15:0] mdl [256];
    int oe_run = 0, we_run = 0, since_oe = 100, last_wp = 0;
    int we_oe_bad = 0, overlap_bad = 0, standby_bad = 0, hold_bad = 0;
    int gap_bad = 0, setup_bad = 0, undriven = 0;
    logic [15:0] wa, wd;
    logic        prev_dq_oe = 1'b0, prev_setup_ok = 1'b0;

    always_comb begin
        mem_dq_in = 16'h6969;
        if (!mem_ce_n && !mem_oe_n && mem_we_n && oe_run >= EXP_ACC) begin
            mem_dq_in = mdl[mem_addr[7:0]];
            if (mem_be_n[1]) mem_dq_in[15:8] = 8'hC3;
            if (mem_be_n[0]) mem_dq_in[7:0]  = 8'hC3;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_we_n && !mem_oe_n) we_oe_bad++;
            if (mem_dq_oe && !mem_oe_n) overlap_bad++;
            if (!busy && (!mem_ce_n || mem_be_n != 2'b11)) standby_bad++;
            if (mem_dq_oe && !prev_dq_oe && since_oe < EXP_HZ + 1) gap_bad++;
            if (!mem_we_n) begin
                if (we_run == 0 && !prev_setup_ok) setup_bad++;
                if (!mem_dq_oe) undriven++;
                if (!mem_be_n[1]) mdl[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
                if (!mem_be_n[0]) mdl[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
                wa = mem_addr; wd = mem_dq_out;
                we_run++;
            end else if (we_run != 0) begin
                if (mem_addr !== wa || mem_dq_out !== wd || !mem_dq_oe || mem_ce_n) hold_bad++;
                last_wp = we_run;
                we_run  = 0;
            end
            if (!mem_oe_n) begin oe_run++; since_oe = 0; end
            else begin oe_run = 0; if (since_oe < 100) since_oe++; end
            prev_dq_oe    = mem_dq_oe;
            prev_setup_ok = !mem_ce_n && mem_we_n && mem_dq_oe;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_req(input logic w, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] m, output logic [15:0] got,
                          output int nval, output int nbusy);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; be_n = m;
        @(negedge clk);
        req = 1'b0;
        nval = 0; nbusy = 0; got = 'x;
        while (busy) begin
            nbusy++;
            if (rvalid) begin nval++; got = rdata; end
            @(negedge clk);
        end
        if (rvalid) begin nval++; got = rdata; end
    endtask

    // {we, addr, wdata, be_n, expected read}
    localparam logic [50:0] VEC [13] = '{
        {1'b1, 16'h0010, 16'hA55A, 2'b00, 16'h0000},
        {1'b1, 16'h0021, 16'h1234, 2'b10, 16'h0000},
        {1'b1, 16'h0032, 16'hBEEF, 2'b01, 16'h0000},
        {1'b1, 16'h0043, 16'hFFFF, 2'b11, 16'h0000},
        {1'b0, 16'h0010, 16'h0000, 2'b00, 16'hA55A},
        {1'b0, 16'h0021, 16'h0000, 2'b00, 16'h0034},
        {1'b0, 16'h0032, 16'h0000, 2'b00, 16'hBE00},
        {1'b0, 16'h0043, 16'h0000, 2'b00, 16'h0000},
        {1'b0, 16'h0010, 16'h0000, 2'b10, 16'h005A},
        {1'b0, 16'h0010, 16'h0000, 2'b01, 16'hA500},
        {1'b0, 16'h0021, 16'h0000, 2'b11, 16'h0000},
        {1'b1, 16'h0060, 16'hABCD, 2'b00, 16'h0000},
        {1'b0, 16'h0060, 16'h0000, 2'b00, 16'hABCD}
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        int nval, nbusy;
        for (int i = 0; i < 256; i++) mdl[i] = 16'h0000;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 strobes in reset", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'h7);
        chk("R1 byte strobes in reset", {30'd0, mem_be_n}, 32'h3);
        chk("R1 busy/rvalid/drive in reset", {29'd0, busy, rvalid, mem_dq_oe}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle after reset", {27'd0, busy, rvalid, mem_dq_oe, mem_ce_n, mem_oe_n}, 32'h3);

        // table walk
        for (int i = 0; i < 13; i++) begin
            logic [50:0] v;
            v = VEC[i];
            do_req(v[50], v[49:34], v[33:18], v[17:16], got, nval, nbusy);
            if (v[50]) begin
                chk("R10 write busy cycles", nbusy, EXP_WP + 2);
                chk("R4 no rvalid on write", nval, 0);
            end else begin
                chk("R10 read busy cycles", nbusy, EXP_ACC + EXP_HZ);
                chk("R4 one rvalid per read", nval, 1);
                chk(v[17:16] == 2'b00 ? "R3 read data" : "R5 masked read data", got, v[15:0]);
            end
        end

        // R8: lane-masked writes seen in the model
        chk("R8 lower-only write", mdl[8'h21], 16'h0034);
        chk("R8 upper-only write", mdl[8'h32], 16'hBE00);
        chk("R8 fully masked write", mdl[8'h43], 16'h0000);

        // R10: request during busy is ignored
        do_req(1'b1, 16'h0050, 16'h1111, 2'b00, got, nval, nbusy);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 16'h0050; be_n = 2'b00;
        @(negedge clk);
        req = 1'b1; we = 1'b1; wdata = 16'h2222;
        @(negedge clk);
        req = 1'b0;
        while (busy) @(negedge clk);
        do_req(1'b0, 16'h0050, 16'h0000, 2'b00, got, nval, nbusy);
        chk("R10 request while busy ignored", got, 16'h1111);
        chk("R10 model untouched", mdl[8'h50], 16'h1111);

        // monitor results
        repeat (2) @(negedge clk);
        chk("R6 write pulse length", last_wp, EXP_WP);
        chk("R6 setup cycle before pulse", setup_bad, 0);
        chk("R6 data driven during pulse", undriven, 0);
        chk("R7 hold cycle stable", hold_bad, 0);
        chk("R9 no drive while output enabled", overlap_bad, 0);
        chk("R9 turnaround gap", gap_bad, 0);
        chk("R2 standby when idle", standby_bad, 0);
        chk("R11 no strobe overlap", we_oe_bad, 0);
        finish_run();
    end
endmodule